// File: doc/BRIEF.md
# Plasma Sub-field Drive Sequencer

This block produces the timing strobes for the two electrode driver boards of a plasma panel. The strobes go to the sustain-electrode (X) board and to the scan-electrode (Y) board. A frame begins on a frame-sync pulse. The first phase is a single write ramp that conditions every cell. A programmable number of sub-fields follows. Each sub-field walks through addressing, sustaining and erasing. While sustaining, both boards receive trains of energy-recovery and clamp strobes. The two boards get the same trains in opposite polarity, and a dead-time gap separates the high-side strobes from the low-side strobes.

To limit panel power, the number of sustain cycles in each sub-field is its nominal weight scaled down by the upper bits of an average-picture-level input. The weights, the sub-field count and the picture level are all captured when the frame starts. All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `pdp_subfield_seq`

## Requirements
- R1: After reset, and whenever no frame is running, every strobe, phase flag and `phase_done` is low.
- R2: A `frame_sync` high at a clock edge while idle starts a frame. From the next cycle, `write_ph` and `y_ramp_up` are high for exactly T_WRITE cycles. The write ramp occurs once per frame only.
- R3: After the write phase, each sub-field runs addressing, then sustaining, then erasing, in that order. The number of sub-fields is `sf_count`, clamped to MAX_SF. A count of zero ends the frame after the write phase.
- R4: Addressing lasts T_ADDR_LINE*N_LINES cycles. `addr_ph`, `y_scan_en` and `x_shelf_addr` are high in exactly those cycles.
- R5: Erasing lasts T_ERASE cycles. `erase_ph`, `y_ramp_dn` and `x_shelf_erase` are high in exactly those cycles.
- R6: One sustain cycle is 2*(2*T_STROBE+T_DEAD) clocks. On Y it gives, in this order: `y_er_h` for T_STROBE, `y_sus_h` for T_STROBE, T_DEAD idle, `y_er_l` for T_STROBE, `y_sus_l` for T_STROBE, T_DEAD idle.
- R7: X receives the same pattern shifted by half a cycle. X runs its low-side pair while Y runs its high-side pair, and the reverse.
- R8: On each electrode, a high-side strobe and a low-side strobe are never active together. At least T_DEAD (>= 2) idle cycles pass between the end of a high-side strobe and the start of a low-side strobe.
- R9: Sub-field i has a weight in `sf_weights[i*CNT_W +: CNT_W]`, with sub-field 0 in the lowest bits. It runs floor(w*(4-k)/4) sustain cycles, where k = `apl[7:6]`. When this count is zero the sustain phase is skipped and erasing follows addressing directly.
- R10: `sf_weights`, `sf_count` and `apl` are sampled only at frame start. Changes to them during a frame do not alter that frame.
- R11: A `frame_sync` that arrives while a frame is running, including in the final erase cycle, is ignored.
- R12: `phase_done` is high for one cycle, on the last cycle of each write, address, sustain and erase phase.
- R13: At most one of the four phase flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start request, sampled while idle |
| sf_count | input | SF_W | Number of sub-fields in the frame |
| sf_weights | input | MAX_SF*CNT_W | Nominal sustain-cycle weight per sub-field |
| apl | input | APL_W | Average picture level |
| write_ph | output | 1 | Write-ramp phase flag |
| addr_ph | output | 1 | Addressing phase flag |
| sust_ph | output | 1 | Sustaining phase flag |
| erase_ph | output | 1 | Erasing phase flag |
| phase_done | output | 1 | Last cycle of the current phase |
| x_sus_h | output | 1 | X clamp high |
| x_sus_l | output | 1 | X clamp low |
| x_er_h | output | 1 | X energy recovery high |
| x_er_l | output | 1 | X energy recovery low |
| x_shelf_addr | output | 1 | X shelf level during addressing |
| x_shelf_erase | output | 1 | X negative shelf during erasing |
| y_ramp_up | output | 1 | Y write ramp switch |
| y_ramp_dn | output | 1 | Y erase ramp-down switch |
| y_scan_en | output | 1 | Y scan block enable |
| y_sus_h | output | 1 | Y clamp high |
| y_sus_l | output | 1 | Y clamp low |
| y_er_h | output | 1 | Y energy recovery high |
| y_er_l | output | 1 | Y energy recovery low |

## Verification
A new frame request can land on the same cycle that the last erase phase finishes and raises `phase_done`. In that cycle the block must still be treated as busy. The bench holds `frame_sync` high in exactly that final erase cycle and keeps it high one cycle more. The reference model then expects one idle cycle, followed by the write ramp starting one cycle later. A second case puts a skipped sustain phase (zero scaled count) at the boundary between the end of addressing and the start of erasing. Both cases are judged cycle by cycle against the behavioural model.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WRITE = 3'd1,
    PH_ADDR  = 3'd2,
    PH_SUST  = 3'd3,
    PH_ERASE = 3'd4
  } phase_e;
endpackage

// File: rtl/pdp_apl_scale.sv
module pdp_apl_scale #(
  parameter int MAX_SF = 4,
  parameter int CNT_W  = 6,
  parameter int APL_W  = 8,
  parameter int LUT_B  = 2
) (
  input  logic [MAX_SF*CNT_W-1:0] weights,
  input  logic [LUT_B-1:0]        level_hi,
  output logic [MAX_SF*CNT_W-1:0] scaled
);
  localparam int PROD_W = CNT_W + LUT_B;

  // factor = 2^LUT_B - level_hi, so the darkest pictures keep the full count
  logic [LUT_B:0] factor;
  assign factor = {1'b1, {LUT_B{1'b0}}} - {1'b0, level_hi};

  for (genvar i = 0; i < MAX_SF; i++) begin : g_sf
    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(weights[i*CNT_W +: CNT_W]) * PROD_W'(factor);
    assign scaled[i*CNT_W +: CNT_W] = CNT_W'(prod >> LUT_B);
  end

  initial begin
    if (APL_W < LUT_B) $error("picture level narrower than lookup index");
  end
endmodule

// File: rtl/pdp_phase_ctrl.sv
module pdp_phase_ctrl
  import pdp_seq_pkg::*;
#(
  parameter int MAX_SF      = 4,
  parameter int SF_W        = 3,
  parameter int CNT_W       = 6,
  parameter int T_WRITE     = 6,
  parameter int T_ADDR_LINE = 2,
  parameter int N_LINES     = 3,
  parameter int T_ERASE     = 4,
  parameter int SUS_PER     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_sync,
  input  logic [SF_W-1:0]         sf_count,
  input  logic [MAX_SF*CNT_W-1:0] scaled_in,
  output phase_e                  phase,
  output logic                    phase_done
);
  localparam int T_ADDR  = T_ADDR_LINE * N_LINES;
  localparam int MAX_SUS = ((1 << CNT_W) - 1) * SUS_PER;
  localparam int MAX_A   = (T_WRITE > T_ADDR) ? T_WRITE : T_ADDR;
  localparam int MAX_B   = (T_ERASE > MAX_SUS) ? T_ERASE : MAX_SUS;
  localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int DUR_W   = $clog2(MAX_DUR + 1);
  localparam int SFI_W   = $clog2(MAX_SF);

  phase_e           st;
  logic [DUR_W-1:0] cnt, dur;
  logic [SFI_W-1:0] sf_idx;
  logic [SF_W-1:0]  nsf, nsf_clamped;
  logic [CNT_W-1:0] pulses [MAX_SF];
  logic [CNT_W-1:0] cur_pulses;
  logic             last;

  assign cur_pulses  = pulses[sf_idx];
  assign nsf_clamped = (sf_count > SF_W'(MAX_SF)) ? SF_W'(MAX_SF) : sf_count;

  always_comb begin
    case (st)
      PH_WRITE: dur = DUR_W'(T_WRITE);
      PH_ADDR:  dur = DUR_W'(T_ADDR);
      PH_SUST:  dur = DUR_W'(cur_pulses) * DUR_W'(SUS_PER);
      PH_ERASE: dur = DUR_W'(T_ERASE);
      default:  dur = '0;
    endcase
  end

  assign last       = (cnt == dur - DUR_W'(1));
  assign phase_done = (st != PH_IDLE) && last;
  assign phase      = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      sf_idx <= '0;
      nsf    <= '0;
      for (int i = 0; i < MAX_SF; i++) pulses[i] <= '0;
    end else if (st == PH_IDLE) begin
      if (frame_sync) begin
        st     <= PH_WRITE;
        cnt    <= '0;
        sf_idx <= '0;
        nsf    <= nsf_clamped;
        for (int i = 0; i < MAX_SF; i++) pulses[i] <= scaled_in[i*CNT_W +: CNT_W];
      end
    end else if (!last) begin
      cnt <= cnt + DUR_W'(1);
    end else begin
      cnt <= '0;
      case (st)
        PH_WRITE: st <= (nsf == '0) ? PH_IDLE : PH_ADDR;
        PH_ADDR:  st <= (cur_pulses == '0) ? PH_ERASE : PH_SUST;
        PH_SUST:  st <= PH_ERASE;
        PH_ERASE: begin
          if (SF_W'(sf_idx) + SF_W'(1) == nsf) st <= PH_IDLE;
          else begin
            st     <= PH_ADDR;
            sf_idx <= sf_idx + SFI_W'(1);
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  a_r2_write_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_WRITE && $past(st) != PH_WRITE) |-> $past(st) == PH_IDLE);
  a_r3_sust_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SUST && $past(st) != PH_SUST) |-> $past(st) == PH_ADDR);
  a_r3_erase_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_ERASE && $past(st) != PH_ERASE) |-> ($past(st) == PH_SUST || $past(st) == PH_ADDR));
  a_r11_busy_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PH_IDLE && frame_sync) |=> $stable(nsf));
  a_r12_done_moves: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> st != $past(st));
  a_r12_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_done && st != PH_IDLE) |=> st == $past(st));
endmodule

// File: rtl/pdp_sus_lane.sv
module pdp_sus_lane #(
  parameter int S      = 2,
  parameter int D      = 2,
  parameter int OFFSET = 0,
  parameter int POS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [POS_W-1:0] pos,
  output logic             er_h,
  output logic             sus_h,
  output logic             er_l,
  output logic             sus_l
);
  localparam int H     = 2 * S + D;
  localparam int P     = 2 * H;
  localparam int GAP_W = $clog2(D + 1);
  localparam logic [POS_W-1:0] Q_SH = POS_W'(S);
  localparam logic [POS_W-1:0] Q_HE = POS_W'(2 * S);
  localparam logic [POS_W-1:0] Q_LS = POS_W'(H);
  localparam logic [POS_W-1:0] Q_LM = POS_W'(H + S);
  localparam logic [POS_W-1:0] Q_LE = POS_W'(H + 2 * S);

  logic [POS_W-1:0] q;
  assign q = POS_W'((32'(pos) + OFFSET) % P);

  // recovery strobe leads the clamp strobe on each side
  assign er_h  = active && (q < Q_SH);
  assign sus_h = active && (q >= Q_SH) && (q < Q_HE);
  assign er_l  = active && (q >= Q_LS) && (q < Q_LM);
  assign sus_l = active && (q >= Q_LM) && (q < Q_LE);

  logic             hi, lo, lo_q;
  logic [GAP_W-1:0] gap;
  assign hi = er_h | sus_h;
  assign lo = er_l | sus_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= GAP_W'(D);
      lo_q <= 1'b0;
    end else begin
      lo_q <= lo;
      if (hi) gap <= '0;
      else if (gap != GAP_W'(D)) gap <= gap + GAP_W'(1);
    end
  end

  a_r8_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && !lo_q) |-> gap == GAP_W'(D));
  a_r6_recovery_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_h) |-> $past(er_h));

  initial begin
    if (D < 2) $error("dead time below two clocks");
  end
endmodule

// File: rtl/pdp_subfield_seq.sv
module pdp_subfield_seq
  import pdp_seq_pkg::*;
#(
  parameter int MAX_SF      = 4,
  parameter int CNT_W       = 6,
  parameter int APL_W       = 8,
  parameter int LUT_B       = 2,
  parameter int T_WRITE     = 6,
  parameter int T_ADDR_LINE = 2,
  parameter int N_LINES     = 3,
  parameter int T_ERASE     = 4,
  parameter int T_STROBE    = 2,
  parameter int T_DEAD      = 2,
  localparam int SF_W       = $clog2(MAX_SF + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_sync,
  input  logic [SF_W-1:0]         sf_count,
  input  logic [MAX_SF*CNT_W-1:0] sf_weights,
  input  logic [APL_W-1:0]        apl,
  output logic                    write_ph,
  output logic                    addr_ph,
  output logic                    sust_ph,
  output logic                    erase_ph,
  output logic                    phase_done,
  output logic                    x_sus_h,
  output logic                    x_sus_l,
  output logic                    x_er_h,
  output logic                    x_er_l,
  output logic                    x_shelf_addr,
  output logic                    x_shelf_erase,
  output logic                    y_ramp_up,
  output logic                    y_ramp_dn,
  output logic                    y_scan_en,
  output logic                    y_sus_h,
  output logic                    y_sus_l,
  output logic                    y_er_h,
  output logic                    y_er_l
);
  localparam int HALF    = 2 * T_STROBE + T_DEAD;
  localparam int SUS_PER = 2 * HALF;
  localparam int POS_W   = $clog2(SUS_PER);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SUS_PER - 1);

  logic [MAX_SF*CNT_W-1:0] scaled;
  logic                    apl_unused;
  phase_e                  phase;
  logic [POS_W-1:0]        pos;

  assign apl_unused = ^apl[APL_W-LUT_B-1:0];

  pdp_apl_scale #(.MAX_SF(MAX_SF), .CNT_W(CNT_W), .APL_W(APL_W), .LUT_B(LUT_B)) u_scale (
    .weights (sf_weights),
    .level_hi(apl[APL_W-1 -: LUT_B]),
    .scaled  (scaled)
  );

  pdp_phase_ctrl #(
    .MAX_SF(MAX_SF), .SF_W(SF_W), .CNT_W(CNT_W), .T_WRITE(T_WRITE),
    .T_ADDR_LINE(T_ADDR_LINE), .N_LINES(N_LINES), .T_ERASE(T_ERASE), .SUS_PER(SUS_PER)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .sf_count  (sf_count),
    .scaled_in (scaled),
    .phase     (phase),
    .phase_done(phase_done)
  );

  assign write_ph = (phase == PH_WRITE);
  assign addr_ph  = (phase == PH_ADDR);
  assign sust_ph  = (phase == PH_SUST);
  assign erase_ph = (phase == PH_ERASE);

  assign y_ramp_up     = write_ph;
  assign y_scan_en     = addr_ph;
  assign x_shelf_addr  = addr_ph;
  assign y_ramp_dn     = erase_ph;
  assign x_shelf_erase = erase_ph;

  // position inside one sustain cycle, restarted at every sustain phase
  always_ff @(posedge clk) begin
    if (!rst_n || !sust_ph) pos <= '0;
    else if (pos == POS_LAST) pos <= '0;
    else pos <= pos + POS_W'(1);
  end

  pdp_sus_lane #(.S(T_STROBE), .D(T_DEAD), .OFFSET(0), .POS_W(POS_W)) u_ylane (
    .clk(clk), .rst_n(rst_n), .active(sust_ph), .pos(pos),
    .er_h(y_er_h), .sus_h(y_sus_h), .er_l(y_er_l), .sus_l(y_sus_l)
  );

  pdp_sus_lane #(.S(T_STROBE), .D(T_DEAD), .OFFSET(HALF), .POS_W(POS_W)) u_xlane (
    .clk(clk), .rst_n(rst_n), .active(sust_ph), .pos(pos),
    .er_h(x_er_h), .sus_h(x_sus_h), .er_l(x_er_l), .sus_l(x_sus_l)
  );

  a_r7_y_high_x_low: assert property (@(posedge clk) disable iff (!rst_n)
    (y_sus_h || y_er_h) |-> (x_sus_l || x_er_l));
  a_r7_x_high_y_low: assert property (@(posedge clk) disable iff (!rst_n)
    x_sus_h |-> y_sus_l);
  a_r13_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({write_ph, addr_ph, sust_ph, erase_ph}));
endmodule

// File: tb/sim_pdp_subfield_seq.sv
`timescale 1ns/1ps
module sim_pdp_subfield_seq;
  localparam int MAX_SF = 4, CNT_W = 6, APL_W = 8;
  localparam int TW = 6, TAL = 2, NL = 3, TE = 4, S = 2, D = 2;
  localparam int TA = TAL * NL;
  localparam int H = 2 * S + D;
  localparam int P = 2 * H;

  localparam int B_WR = 17, B_AD = 16, B_SU = 15, B_ER = 14, B_DN = 13;
  localparam int B_XSH = 12, B_XSL = 11, B_XEH = 10, B_XEL = 9, B_XAS = 8, B_XES = 7;
  localparam int B_YRU = 6, B_YRD = 5, B_YSC = 4, B_YSH = 3, B_YSL = 2, B_YEH = 1, B_YEL = 0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rst_n, frame_sync;
  logic [2:0]              sf_count;
  logic [MAX_SF*CNT_W-1:0] sf_weights;
  logic [APL_W-1:0]        apl;
  logic write_ph, addr_ph, sust_ph, erase_ph, phase_done;
  logic x_sus_h, x_sus_l, x_er_h, x_er_l, x_shelf_addr, x_shelf_erase;
  logic y_ramp_up, y_ramp_dn, y_scan_en, y_sus_h, y_sus_l, y_er_h, y_er_l;

  pdp_subfield_seq #(
    .MAX_SF(MAX_SF), .CNT_W(CNT_W), .APL_W(APL_W), .LUT_B(2), .T_WRITE(TW),
    .T_ADDR_LINE(TAL), .N_LINES(NL), .T_ERASE(TE), .T_STROBE(S), .T_DEAD(D)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .sf_count(sf_count),
    .sf_weights(sf_weights), .apl(apl),
    .write_ph(write_ph), .addr_ph(addr_ph), .sust_ph(sust_ph), .erase_ph(erase_ph),
    .phase_done(phase_done),
    .x_sus_h(x_sus_h), .x_sus_l(x_sus_l), .x_er_h(x_er_h), .x_er_l(x_er_l),
    .x_shelf_addr(x_shelf_addr), .x_shelf_erase(x_shelf_erase),
    .y_ramp_up(y_ramp_up), .y_ramp_dn(y_ramp_dn), .y_scan_en(y_scan_en),
    .y_sus_h(y_sus_h), .y_sus_l(y_sus_l), .y_er_h(y_er_h), .y_er_l(y_er_l)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit cur_idle = 1'b1;
  logic [17:0] qv[$];
  string       qt[$];

  function automatic logic [17:0] obs();
    return {write_ph, addr_ph, sust_ph, erase_ph, phase_done,
            x_sus_h, x_sus_l, x_er_h, x_er_l, x_shelf_addr, x_shelf_erase,
            y_ramp_up, y_ramp_dn, y_scan_en, y_sus_h, y_sus_l, y_er_h, y_er_l};
  endfunction

  task automatic push(logic [17:0] v, string t);
    qv.push_back(v);
    qt.push_back(v[B_DN] ? {t, " R12"} : t);
  endtask

  // Behavioural reference: the whole frame as one expected vector per cycle
  task automatic build_frame(int n, logic [MAX_SF*CNT_W-1:0] w, logic [APL_W-1:0] a);
    int k = int'(a[7:6]);
    int nn = (n > MAX_SF) ? MAX_SF : n;
    logic [17:0] v;
    for (int c = 0; c < TW; c++) begin  // R2 single write ramp
      v = '0; v[B_WR] = 1; v[B_YRU] = 1; v[B_DN] = (c == TW - 1);
      push(v, "R2");
    end
    for (int s = 0; s < nn; s++) begin  // R3 order per sub-field
      int pl = (int'(w[s*CNT_W +: CNT_W]) * (4 - k)) / 4;  // R9
      for (int c = 0; c < TA; c++) begin
        v = '0; v[B_AD] = 1; v[B_YSC] = 1; v[B_XAS] = 1; v[B_DN] = (c == TA - 1);
        push(v, "R3 R4");
      end
      for (int c = 0; c < pl * P; c++) begin
        int yq = c % P;
        int xq = (c % P + H) % P;
        v = '0; v[B_SU] = 1; v[B_DN] = (c == pl * P - 1);
        v[B_YEH] = (yq < S);           v[B_YSH] = (yq >= S && yq < 2*S);
        v[B_YEL] = (yq >= H && yq < H+S); v[B_YSL] = (yq >= H+S && yq < H+2*S);
        v[B_XEH] = (xq < S);           v[B_XSH] = (xq >= S && xq < 2*S);
        v[B_XEL] = (xq >= H && xq < H+S); v[B_XSL] = (xq >= H+S && xq < H+2*S);
        push(v, "R6 R7 R8 R9");
      end
      for (int c = 0; c < TE; c++) begin
        v = '0; v[B_ER] = 1; v[B_YRD] = 1; v[B_XES] = 1; v[B_DN] = (c == TE - 1);
        push(v, "R3 R5");
      end
    end
  endtask

  task automatic step();
    logic [17:0] e;
    string t;
    if (frame_sync && cur_idle) build_frame(int'(sf_count), sf_weights, apl);
    @(negedge clk);
    cyc++;
    if (qv.size() != 0) begin e = qv.pop_front(); t = qt.pop_front(); end
    else begin e = '0; t = "R1 R10 R11 R13"; end
    checks++;
    if (obs() !== e) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", t, cyc, obs(), e);
    end
    cur_idle = (e == '0);
  endtask

  task automatic run_to_idle();
    step();
    while (!cur_idle) step();
  endtask

  initial begin
    rst_n = 1'b0; frame_sync = 1'b0; sf_count = '0; sf_weights = '0; apl = '0;
    repeat (3) @(negedge clk);
    checks++;  // R1 outputs quiet in reset
    if (obs() !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %b expected %b", obs(), 18'b0);
    end
    rst_n = 1'b1;
    repeat (3) step();

    // Frame A: three sub-fields, full weight; inputs disturbed mid-frame (R10, R11)
    sf_count = 3'd3; sf_weights = {6'd0, 6'd3, 6'd2, 6'd1}; apl = 8'h10;
    frame_sync = 1'b1; step(); frame_sync = 1'b0;
    repeat (5) step();
    sf_count = 3'd1; sf_weights = {4{6'd7}}; apl = 8'hFF;
    frame_sync = 1'b1; step(); frame_sync = 1'b0;
    run_to_idle();
    repeat (2) step();

    // Frame B: brightest picture, second sub-field scales to zero (R9)
    sf_count = 3'd2; sf_weights = {6'd0, 6'd0, 6'd1, 6'd4}; apl = 8'hC3;
    frame_sync = 1'b1; step(); frame_sync = 1'b0;
    run_to_idle();
    step();

    // Frame C: zero sub-fields, write ramp only (R3)
    sf_count = 3'd0;
    frame_sync = 1'b1; step(); frame_sync = 1'b0;
    run_to_idle();
    step();

    // Frame D: count above MAX_SF is clamped (R3), half scale (R9)
    sf_count = 3'd7; sf_weights = {6'd1, 6'd1, 6'd2, 6'd2}; apl = 8'h80;
    frame_sync = 1'b1; step(); frame_sync = 1'b0;
    while (qv.size() != 0) step();
    // request in final erase cycle is ignored (R11), the next one starts a frame
    sf_count = 3'd1; sf_weights = {6'd0, 6'd0, 6'd0, 6'd2}; apl = 8'h40;
    frame_sync = 1'b1; step(); step(); frame_sync = 1'b0;
    run_to_idle();
    repeat (3) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog: got frame still running, expected idle");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule